// File: doc/BRIEF.md
# Line-Sensor Frame Synchroniser and Pixel Unpacker

This block sits behind a swept line-scan thermal sensor that delivers one byte per accepted clock, each byte packing two 4-bit pixels. Frames are 281 columns long: 280 image columns followed by one marker column of four bytes. The block finds frame boundaries by hunting for a two-byte marker signature. It confirms that the signature recurs at the frame period before it trusts the alignment. Once locked, it tracks a missed signature by coasting for one frame, and it gives up alignment after a second consecutive miss.

While aligned, every image byte is split into two pixels. The upper nibble goes to the odd-numbered sensor row and the lower nibble to the even-numbered row below it. Each pixel pair leaves with its column index and both row indices. The last two marker bytes carry thermal and status codes. These are held in two output registers, and a frame-end pulse announces that both are fresh. A frame-start pulse travels with the first pixel pair of column 0.

Top module: `fsync_unpacker`

## Requirements
- R1: After synchronous reset, lock_state is 0 (hunt), px_valid, frame_start and frame_end are low, and temp_code and aux_code are 0.
- R2: A byte is a marker byte when bits 7..5 are all 1 and bits 3..0 are all 0, whatever bit 4 holds. A signature is two consecutive accepted marker bytes. A lone marker byte does not leave hunt.
- R3: lock_state encodes hunt=0, verify=1, locked=2, lost=3. A signature seen in hunt moves to verify. The second byte of that signature is taken as byte 1121 of a 1124-byte frame, counting from byte 0. In verify, the signature must end at byte 1121 of two successive frames before the state becomes locked. One miss at that slot returns to hunt.
- R4: In locked, a miss at the slot moves to lost. In lost, a hit moves back to locked and a miss moves to hunt.
- R5: For image byte p (0..1119), the bytes are taken column by column with 4 bytes per column. px_col is p/4, px_row_odd is 2*(p mod 4), and px_row_even is px_row_odd+1, all counted from 0. px_odd is byte bits 7..4 and px_even is bits 3..0, with bit 3 of each nibble being the MSB.
- R6: Pixel outputs appear one clock after the byte is accepted. They appear only in locked or lost, and never for the four marker-column bytes (1120..1123).
- R7: frame_start is high exactly with the pixel output of byte 0, in locked or lost.
- R8: In locked or lost, byte 1122 is stored in temp_code and byte 1123 in aux_code. frame_end pulses one clock after byte 1123, with the new aux_code already visible. In hunt and verify, both registers hold their value and frame_end stays low.
- R9: A cycle with in_valid low advances nothing and produces no pixel or marker pulse.
- R10: A signature inside the image bytes while locked changes neither the state nor the alignment, and its bytes are emitted as ordinary pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Packed pixel pair or marker byte |
| px_valid | output | 1 | Pixel pair valid |
| px_col | output | 9 | Column index 0..279 |
| px_row_odd | output | 3 | Row of px_odd (even number, 0-based) |
| px_row_even | output | 3 | Row of px_even |
| px_odd | output | 4 | Pixel from upper nibble |
| px_even | output | 4 | Pixel from lower nibble |
| frame_start | output | 1 | With first pixel pair of a frame |
| frame_end | output | 1 | Status registers just refreshed |
| temp_code | output | 8 | Third marker-column byte |
| aux_code | output | 8 | Fourth marker-column byte |
| lock_state | output | 2 | 0 hunt, 1 verify, 2 locked, 3 lost |

## Verification
Two pairs of functions collide in single cycles. First, the signature detector fires on an image byte in the same cycle that the pixel path emits that byte. The bench plants a marker pair inside the image area of a locked frame. It then requires those bytes to leave as ordinary pixels, the state to stay locked, and the following frame to keep its column numbering. Second, the slot verdict on the second marker byte coincides with the start of status capture. The bench corrupts that byte while locked and requires the state to fall to lost in that same cycle, while the following two bytes are still captured and frame_end still fires. A second corrupted frame must drop to hunt before capture, so the registers must keep the previous frame's codes.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2,
        ST_LOST   = 2'd3
    } lock_state_e;

    typedef struct packed {
        logic [3:0] hi;   // odd-row pixel
        logic [3:0] lo;   // even-row pixel
    } nib_pair_t;

    localparam int BYTE_W = 8;

    // Marker byte: top three bits set, low nibble clear, bit 4 free.
    function automatic logic is_marker_byte(input logic [BYTE_W-1:0] b);
        return (b[7:5] == 3'b111) && (b[3:0] == 4'h0);
    endfunction

    function automatic nib_pair_t split_byte(input logic [BYTE_W-1:0] b);
        nib_pair_t r;
        r.hi = b[7:4];
        r.lo = b[3:0];
        return r;
    endfunction

    function automatic logic is_tracking(input lock_state_e s);
        return (s == ST_LOCKED) || (s == ST_LOST);
    endfunction

endpackage

// File: rtl/fsync_match.sv
module fsync_match
    import fsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              sig_hit
);
    logic cur_mark;
    logic prev_mark_q;

    assign cur_mark = is_marker_byte(in_byte);

    always_ff @(posedge clk) begin
        if (rst)           prev_mark_q <= 1'b0;
        else if (in_valid) prev_mark_q <= cur_mark;
    end

    assign sig_hit = in_valid && cur_mark && prev_mark_q;

endmodule

// File: rtl/fsync_lock.sv
module fsync_lock
    import fsync_pkg::*;
#(
    parameter int FRAME_LEN = 1124,
    parameter int SIG_POS   = 1121,
    parameter int POS_W     = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             sig_hit,
    output lock_state_e      state,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] SLOT_POS  = POS_W'(SIG_POS);
    localparam logic [POS_W-1:0] AFTER_POS = POS_W'(SIG_POS + 1);

    lock_state_e      st_q;
    logic [POS_W-1:0] pos_q;
    logic             conf_q;
    logic             at_slot;

    assign at_slot = (pos_q == SLOT_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            pos_q  <= '0;
            conf_q <= 1'b0;
        end else if (in_valid) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            unique case (st_q)
                ST_HUNT: begin
                    if (sig_hit) begin
                        st_q   <= ST_VERIFY;
                        pos_q  <= AFTER_POS;
                        conf_q <= 1'b0;
                    end
                end
                ST_VERIFY: begin
                    if (at_slot) begin
                        if (!sig_hit)    st_q   <= ST_HUNT;
                        else if (conf_q) st_q   <= ST_LOCKED;
                        else             conf_q <= 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (at_slot && !sig_hit) st_q <= ST_LOST;
                end
                ST_LOST: begin
                    if (at_slot) st_q <= sig_hit ? ST_LOCKED : ST_HUNT;
                end
            endcase
        end
    end

    assign state = st_q;
    assign pos   = pos_q;

    // R3: hunt can only stay or move to verify
    a_r3_hunt_exit: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HUNT) |=> (st_q == ST_HUNT || st_q == ST_VERIFY));
    // R3: verify is left only at the expected slot
    a_r3_verify_slot: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_VERIFY && !(in_valid && at_slot)) |=> (st_q == ST_VERIFY));
    // R4: a single miss from locked never reaches hunt
    a_r4_single_miss: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOCKED) |=> (st_q != ST_HUNT));
    // R4: lost never jumps to verify
    a_r4_lost_exit: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOST) |=> (st_q != ST_VERIFY));
    // R3: position stays inside the frame
    a_r3_pos_range: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

endmodule

// File: rtl/fsync_unpack.sv
module fsync_unpack
    import fsync_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 280,
    parameter int POS_W = 11,
    parameter int COL_W = 9,
    parameter int ROW_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  lock_state_e       state,
    input  logic [POS_W-1:0]  pos,
    output logic              px_valid,
    output logic [COL_W-1:0]  px_col,
    output logic [ROW_W-1:0]  px_row_odd,
    output logic [ROW_W-1:0]  px_row_even,
    output logic [3:0]        px_odd,
    output logic [3:0]        px_even,
    output logic              frame_start,
    output logic              frame_end,
    output logic [BYTE_W-1:0] temp_code,
    output logic [BYTE_W-1:0] aux_code
);
    localparam int BPC       = ROWS / 2;
    localparam int PIX_BYTES = COLS * BPC;
    localparam logic [POS_W-1:0] PIX_LIM = POS_W'(PIX_BYTES);
    localparam logic [POS_W-1:0] TEMP_AT = POS_W'(PIX_BYTES + 2);
    localparam logic [POS_W-1:0] AUX_AT  = POS_W'(PIX_BYTES + 3);
    localparam logic [POS_W-1:0] BPC_P   = POS_W'(BPC);

    logic             emit;
    logic             is_pix;
    logic [POS_W-1:0] col_full;
    logic [POS_W-1:0] pair_full;
    nib_pair_t        nib;

    assign emit      = in_valid && is_tracking(state);
    assign is_pix    = (pos < PIX_LIM);
    assign col_full  = pos / BPC_P;
    assign pair_full = pos % BPC_P;
    assign nib       = split_byte(in_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            px_valid    <= 1'b0;
            px_col      <= '0;
            px_row_odd  <= '0;
            px_row_even <= '0;
            px_odd      <= '0;
            px_even     <= '0;
            frame_start <= 1'b0;
            frame_end   <= 1'b0;
            temp_code   <= '0;
            aux_code    <= '0;
        end else begin
            px_valid    <= emit && is_pix;
            frame_start <= emit && (pos == '0);
            frame_end   <= emit && (pos == AUX_AT);
            if (emit && is_pix) begin
                px_col      <= col_full[COL_W-1:0];
                px_row_odd  <= {pair_full[ROW_W-2:0], 1'b0};
                px_row_even <= {pair_full[ROW_W-2:0], 1'b1};
                px_odd      <= nib.hi;
                px_even     <= nib.lo;
            end
            if (emit && pos == TEMP_AT) temp_code <= in_byte;
            if (emit && pos == AUX_AT)  aux_code  <= in_byte;
        end
    end

    // R7: frame start travels with the first pair of column 0
    a_r7_start_first: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (px_valid && px_col == '0 && px_row_odd == '0));
    // R6: column index never leaves the image
    a_r6_col_range: assert property (@(posedge clk) disable iff (rst)
        px_valid |-> ({1'b0, px_col} < (COL_W + 1)'(COLS)));
    // R8: frame end never coincides with a pixel
    a_r8_end_alone: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> !px_valid);
    // R8: aux_code moves only together with frame end
    a_r8_aux_with_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(aux_code) |-> frame_end);
    // R9: an idle input cycle produces nothing
    a_r9_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!px_valid && !frame_start && !frame_end));

endmodule

// File: rtl/fsync_unpacker.sv
module fsync_unpacker
    import fsync_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 280
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [7:0]                in_byte,
    output logic                      px_valid,
    output logic [$clog2(COLS)-1:0]   px_col,
    output logic [$clog2(ROWS)-1:0]   px_row_odd,
    output logic [$clog2(ROWS)-1:0]   px_row_even,
    output logic [3:0]                px_odd,
    output logic [3:0]                px_even,
    output logic                      frame_start,
    output logic                      frame_end,
    output logic [7:0]                temp_code,
    output logic [7:0]                aux_code,
    output logic [1:0]                lock_state
);
    localparam int BPC       = ROWS / 2;
    localparam int FRAME_LEN = (COLS + 1) * BPC;
    localparam int SIG_POS   = COLS * BPC + 1;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int COL_W     = $clog2(COLS);
    localparam int ROW_W     = $clog2(ROWS);

    logic             sig_hit;
    lock_state_e      state;
    logic [POS_W-1:0] pos;

    fsync_match u_match (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .sig_hit  (sig_hit)
    );

    fsync_lock #(
        .FRAME_LEN (FRAME_LEN),
        .SIG_POS   (SIG_POS),
        .POS_W     (POS_W)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .sig_hit  (sig_hit),
        .state    (state),
        .pos      (pos)
    );

    fsync_unpack #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .POS_W (POS_W),
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_unpack (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .state       (state),
        .pos         (pos),
        .px_valid    (px_valid),
        .px_col      (px_col),
        .px_row_odd  (px_row_odd),
        .px_row_even (px_row_even),
        .px_odd      (px_odd),
        .px_even     (px_even),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .temp_code   (temp_code),
        .aux_code    (aux_code)
    );

    assign lock_state = state;

    // R2/R3: leaving hunt needs a detected signature
    a_r2_hunt_needs_sig: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HUNT && !sig_hit) |=> (state == ST_HUNT));

endmodule

// File: tb/fsync_unpacker_tb.sv
module fsync_unpacker_tb;
    localparam int CLK_NS = 10;
    localparam int FRAME  = 1124;
    localparam int PIXB   = 1120;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_byte;
    logic       px_valid;
    logic [8:0] px_col;
    logic [2:0] px_row_odd;
    logic [2:0] px_row_even;
    logic [3:0] px_odd;
    logic [3:0] px_even;
    logic       frame_start;
    logic       frame_end;
    logic [7:0] temp_code;
    logic [7:0] aux_code;
    logic [1:0] lock_state;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    fsync_unpacker u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_byte (in_byte),
        .px_valid (px_valid), .px_col (px_col), .px_row_odd (px_row_odd),
        .px_row_even (px_row_even), .px_odd (px_odd), .px_even (px_even),
        .frame_start (frame_start), .frame_end (frame_end),
        .temp_code (temp_code), .aux_code (aux_code), .lock_state (lock_state)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic push(input logic [7:0] b, input logic v);
        in_valid = v;
        in_byte  = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] db3(input int f);
        return {4'(f), 4'hA};
    endfunction

    function automatic logic [7:0] db4(input int f);
        return {4'h3, 4'(f)};
    endfunction

    function automatic logic [7:0] byte_of(input int f, input int p, input bit bad, input bit spur);
        if (p < PIXB) begin
            if (spur && p == 40) return 8'hE0;
            if (spur && p == 41) return 8'hF0;
            return {4'((p + f) % 16), 4'((p % 15) + 1)};
        end
        if (p == PIXB)     return (f % 2 == 1) ? 8'hF0 : 8'hE0;
        if (p == PIXB + 1) return bad ? 8'h01 : (((f / 2) % 2 == 1) ? 8'hF0 : 8'hE0);
        if (p == PIXB + 2) return db3(f);
        return db4(f);
    endfunction

    task automatic send_frame(input int f, input bit exp_px, input bit exp_cap,
                              input bit bad, input bit spur, input bit gaps);
        for (int p = 0; p < FRAME; p++) begin
            logic [7:0]  b;
            logic [25:0] act;
            logic [25:0] exp;
            b = byte_of(f, p, bad, spur);
            if (gaps && (p % 100) == 50) begin
                push(8'h00, 1'b0);
                chk(!px_valid && !frame_start && !frame_end, "R9 idle cycle silent",
                    {29'd0, px_valid, frame_start, frame_end}, 32'd0);
            end
            push(b, 1'b1);
            act = {px_valid, frame_start, frame_end, px_col, px_row_odd, px_row_even, px_odd, px_even};
            if (p < PIXB) begin
                if (exp_px) begin
                    exp = {1'b1, (p == 0), 1'b0, 9'(p / 4), 3'(2 * (p % 4)),
                           3'(2 * (p % 4) + 1), b[7:4], b[3:0]};
                    chk(act == exp, "R5/R6/R7/R10 pixel", {6'd0, act}, {6'd0, exp});
                end else begin
                    chk(!px_valid && !frame_start && !frame_end, "R6 no emit out of lock",
                        {29'd0, px_valid, frame_start, frame_end}, 32'd0);
                end
            end else if (p == FRAME - 1) begin
                if (exp_cap)
                    chk(frame_end && !px_valid && temp_code == db3(f) && aux_code == db4(f),
                        "R8 status capture", {15'd0, frame_end, temp_code, aux_code},
                        {15'd0, 1'b1, db3(f), db4(f)});
                else
                    chk(!frame_end && !px_valid, "R8 no capture",
                        {30'd0, frame_end, px_valid}, 32'd0);
            end else begin
                chk(!px_valid && !frame_end && !frame_start, "R6 marker bytes silent",
                    {29'd0, px_valid, frame_end, frame_start}, 32'd0);
            end
        end
    endtask

    task automatic chk_state(input logic [1:0] exp, input string tag);
        chk(lock_state == exp, tag, {30'd0, lock_state}, {30'd0, exp});
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(lock_state == 2'd0 && !px_valid && !frame_start && !frame_end &&
            temp_code == 8'h00 && aux_code == 8'h00, "R1 reset state",
            {11'd0, lock_state, px_valid, frame_start, frame_end, temp_code, aux_code}, 32'd0);
    endtask

    task automatic t_acquire;
        push(8'h11, 1'b1); push(8'hE0, 1'b1); push(8'h11, 1'b1); push(8'hF0, 1'b1); push(8'h13, 1'b1);
        chk_state(2'd0, "R2 lone marker byte stays in hunt");
        send_frame(0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_state(2'd1, "R3 first signature enters verify");
        send_frame(1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_state(2'd1, "R3 one confirmation still verify");
        send_frame(2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk_state(2'd2, "R3 second confirmation locks");
    endtask

    task automatic t_stream;
        send_frame(3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk_state(2'd2, "R5 locked after full frame");
        send_frame(4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk_state(2'd2, "R9 gaps keep lock");
    endtask

    task automatic t_spurious;
        send_frame(5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        chk_state(2'd2, "R10 spurious signature ignored");
        send_frame(6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        chk_state(2'd3, "R4 one miss gives lost");
    endtask

    task automatic t_recover_and_drop;
        send_frame(7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk_state(2'd2, "R4 hit in lost relocks");
        send_frame(8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        chk_state(2'd3, "R4 miss gives lost again");
        send_frame(9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk_state(2'd0, "R4 second miss gives hunt");
        chk(temp_code == db3(8) && aux_code == db4(8), "R8 codes held in hunt",
            {16'd0, temp_code, aux_code}, {16'd0, db3(8), db4(8)});
    endtask

    task automatic t_verify_miss;
        send_frame(10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk_state(2'd1, "R3 reacquire enters verify");
        send_frame(11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk_state(2'd0, "R3 miss in verify gives hunt");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset;
        t_acquire;
        t_stream;
        t_spurious;
        t_recover_and_drop;
        t_verify_miss;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule